// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block produces the status byte a flash array returns on reads while an embedded byte program or erase runs, is suspended, or has run into its limit. The command decoder gives it a start pulse on the final accepted write edge, along with the operation kind, the target sector, the polled data bit of the byte being programmed and a flag saying whether the target is protected. The array engine reports completion and pulse-count overrun. Each read strobe, one per output-enable or chip-enable read, latches a fresh status byte.

The byte carries several bits, each with its own rule. Bit 7 is the polled data bit. Bit 6 inverts on every read. Bit 5 flags a timeout. Bit 3 marks an erase window. Bit 2 is a second toggle that depends on the read address. When the target is protected, the block gives a short busy period of a fixed number of clock cycles and then signals a return to read mode with no array change. While a sector erase is suspended, reads outside the erasing sector pass array data through.

Top module: `opstat_gen`

## Requirements
- R1: After reset `busy` and `ret_read` are 0, `stat_q` is 8'h00, and a read before any operation returns 8'h00.
- R2: For a byte program, bit 7 of a status read is the inverse of `prog_poll_bit` while busy. After completion it is the true value of `prog_poll_bit`.
- R3: For an erase (kind 1 = sector, kind 2 = chip), bit 7 reads 0 while busy and 1 after completion. In idle reads, bits 6 and 2 keep their last values and bits 5, 4, 3, 1 and 0 are 0.
- R4: While busy, bit 6 inverts on every read at any sector, and the first read after a start returns 1. It holds once the block is idle.
- R5: A `tmo` pulse while running sets bit 5 on every later read. The block then stays busy, ignores `op_done`, and leaves this state only on reset.
- R6: Bit 3 reads 1 during an erase of either kind and 0 during a program.
- R7: Bit 2 inverts on a read during a sector erase only when `rd_sector` equals the target sector. During a chip erase it inverts on every read. During a program it stays 0.
- R8: A program (kind 0) started with `tgt_prot` high keeps `busy` high for PROG_WIN cycles, counted from the start edge, with bit 6 toggling. It then drops `busy` and pulses `ret_read`.
- R9: An erase started with `tgt_prot` high behaves the same way for ERASE_WIN cycles.
- R10: `op_done` sampled while running (and not suspended) makes `busy` low after that edge and pulses `ret_read` high for exactly one cycle.
- R11: While `susp` is high during a sector erase, reads outside the target sector return `arr_data` and leave bits 6 and 2 unchanged. Reads inside the target sector return status with bit 6 held and bit 2 toggling. `op_done` is ignored while suspended.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_start | input | 1 | Final write edge of a program or erase sequence |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| tgt_sector | input | SEC_W | Sector addressed by the operation |
| prog_poll_bit | input | 1 | Bit 7 of the byte being programmed |
| tgt_prot | input | 1 | Target sector(s) protected |
| op_done | input | 1 | Array engine finished |
| tmo | input | 1 | Internal pulse count exceeded |
| susp | input | 1 | Sector erase suspended |
| rd_strobe | input | 1 | One pulse per read |
| rd_sector | input | SEC_W | Sector of the read address |
| arr_data | input | DATA_W | Array data for suspended reads |
| stat_q | output | DATA_W | Byte latched on the last read |
| busy | output | 1 | Embedded or fake-busy operation active |
| ret_read | output | 1 | One-cycle pulse on return to read mode |

## Verification
The bench goes after address sensitivity of bit 2. A design that compared the wrong sector, or that toggled on every read during a sector erase, returns the wrong bit 2 on alternating reads. It counts the protected-target window cycle by cycle, so an off-by-one counter shows up as a busy count of PROG_WIN±1. It also checks suspension: reads outside the erasing sector must pass array data and freeze both toggles, and a completion pulse during suspension must not end the operation. Finally, it checks that a timeout survives `op_done`, that a start while busy changes nothing, and that bit 7 after completion becomes the true polled bit rather than its inverse.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
   typedef enum logic [1:0] {
      KIND_PROG = 2'd0,
      KIND_SECT = 2'd1,
      KIND_CHIP = 2'd2,
      KIND_NONE = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FAKE = 2'd2,
      ST_HANG = 2'd3
   } state_e;

   localparam int BIT_POLL = 7;
   localparam int BIT_TGL  = 6;
   localparam int BIT_TMO  = 5;
   localparam int BIT_ERW  = 3;
   localparam int BIT_TGL2 = 2;
   localparam int STAT_W   = 8;
endpackage

// File: rtl/opstat_seq.sv
module opstat_seq
   import opstat_pkg::*;
#(
   parameter int SEC_W     = 3,
   parameter int PROG_WIN  = 16,
   parameter int ERASE_WIN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_start,
   input  logic [1:0]       op_kind,
   input  logic [SEC_W-1:0] tgt_sector,
   input  logic             prog_poll_bit,
   input  logic             tgt_prot,
   input  logic             op_done,
   input  logic             tmo,
   input  logic             susp,
   output state_e           state_q,
   output kind_e            kind_q,
   output logic [SEC_W-1:0] sec_q,
   output logic             poll_q,
   output logic             start_ok,
   output logic             ret_q
);
   localparam int WIN_MAX = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN;
   localparam int CNT_W   = $clog2(WIN_MAX + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             susp_hold;
   kind_e            kind_in;

   assign kind_in   = kind_e'(op_kind);
   assign start_ok  = op_start && (state_q == ST_IDLE) && (kind_in != KIND_NONE);
   assign susp_hold = susp && (kind_q == KIND_SECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= KIND_PROG;
         sec_q   <= '0;
         poll_q  <= 1'b0;
         cnt_q   <= '0;
         ret_q   <= 1'b0;
      end else begin
         ret_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  kind_q <= kind_in;
                  sec_q  <= tgt_sector;
                  poll_q <= prog_poll_bit;
                  if (tgt_prot) begin
                     state_q <= ST_FAKE;
                     cnt_q   <= (kind_in == KIND_PROG) ? CNT_W'(PROG_WIN - 1)
                                                       : CNT_W'(ERASE_WIN - 1);
                  end else begin
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (tmo) begin
                  state_q <= ST_HANG;
               end else if (op_done && !susp_hold) begin
                  state_q <= ST_IDLE;
                  ret_q   <= 1'b1;
               end
            end
            ST_FAKE: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
                  ret_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_HANG;
         endcase
      end
   end
endmodule

// File: rtl/opstat_tog.sv
module opstat_tog #(
   parameter int NUM_TGL = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [NUM_TGL-1:0] step,
   output logic [NUM_TGL-1:0] tgl_q,
   output logic [NUM_TGL-1:0] tgl_nx
);
   for (genvar i = 0; i < NUM_TGL; i++) begin : g_tgl
      assign tgl_nx[i] = clr ? 1'b0 : (step[i] ? ~tgl_q[i] : tgl_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tgl_q[i] <= 1'b0;
         else        tgl_q[i] <= tgl_nx[i];
      end
   end
endmodule

// File: rtl/opstat_fmt.sv
module opstat_fmt
   import opstat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  state_e            state_q,
   input  kind_e             kind_q,
   input  logic              poll_q,
   input  logic              t6,
   input  logic              t2,
   input  logic              pass_arr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_byte
);
   logic              act;
   logic              is_prog;
   logic [STAT_W-1:0] st_byte;
   logic [DATA_W-1:0] st_wide;

   assign act     = (state_q != ST_IDLE);
   assign is_prog = (kind_q == KIND_PROG);

   always_comb begin
      st_byte           = '0;
      st_byte[BIT_POLL] = act ? (is_prog ? ~poll_q : 1'b0)
                              : (is_prog ?  poll_q : 1'b1);
      st_byte[BIT_TGL]  = t6;
      st_byte[BIT_TMO]  = (state_q == ST_HANG);
      st_byte[BIT_ERW]  = act && !is_prog;
      st_byte[BIT_TGL2] = t2;
   end

   if (DATA_W > STAT_W) begin : g_pad
      assign st_wide = {{(DATA_W - STAT_W){1'b0}}, st_byte};
   end else begin : g_exact
      assign st_wide = st_byte;
   end

   assign rd_byte = pass_arr ? arr_data : st_wide;
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
   import opstat_pkg::*;
#(
   parameter int SEC_W     = 3,
   parameter int DATA_W    = 8,
   parameter int PROG_WIN  = 16,
   parameter int ERASE_WIN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [SEC_W-1:0]  tgt_sector,
   input  logic              prog_poll_bit,
   input  logic              tgt_prot,
   input  logic              op_done,
   input  logic              tmo,
   input  logic              susp,
   input  logic              rd_strobe,
   input  logic [SEC_W-1:0]  rd_sector,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] stat_q,
   output logic              busy,
   output logic              ret_read
);
   localparam int NUM_TGL = 2;

   if (DATA_W < STAT_W) begin : g_bad_w
      $error("opstat_gen: DATA_W must be at least 8");
   end
   if (PROG_WIN < 2 || ERASE_WIN < 2) begin : g_bad_win
      $error("opstat_gen: windows must be at least 2 cycles");
   end
   if (SEC_W < 1) begin : g_bad_sec
      $error("opstat_gen: SEC_W must be positive");
   end

   state_e             state_q;
   kind_e              kind_q;
   logic [SEC_W-1:0]   sec_q;
   logic               poll_q;
   logic               start_ok;
   logic               in_sec;
   logic               hold6;
   logic               pass_arr;
   logic               erase_k;
   logic [NUM_TGL-1:0] step;
   logic [NUM_TGL-1:0] tgl_q;
   logic [NUM_TGL-1:0] tgl_nx;
   logic [DATA_W-1:0]  rd_byte;

   opstat_seq #(
      .SEC_W(SEC_W), .PROG_WIN(PROG_WIN), .ERASE_WIN(ERASE_WIN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .tgt_sector(tgt_sector), .prog_poll_bit(prog_poll_bit),
      .tgt_prot(tgt_prot), .op_done(op_done), .tmo(tmo), .susp(susp),
      .state_q(state_q), .kind_q(kind_q), .sec_q(sec_q), .poll_q(poll_q),
      .start_ok(start_ok), .ret_q(ret_read)
   );

   assign busy     = (state_q != ST_IDLE);
   assign in_sec   = (rd_sector == sec_q);
   assign erase_k  = (kind_q != KIND_PROG);
   assign hold6    = susp && (state_q == ST_RUN) && (kind_q == KIND_SECT);
   assign pass_arr = hold6 && !in_sec;
   assign step[0]  = rd_strobe && busy && !hold6;
   assign step[1]  = rd_strobe && busy && erase_k && ((kind_q == KIND_CHIP) || in_sec);

   opstat_tog #(.NUM_TGL(NUM_TGL)) u_tog (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .step(step),
      .tgl_q(tgl_q), .tgl_nx(tgl_nx)
   );

   opstat_fmt #(.DATA_W(DATA_W)) u_fmt (
      .state_q(state_q), .kind_q(kind_q), .poll_q(poll_q),
      .t6(tgl_nx[0]), .t2(tgl_nx[1]), .pass_arr(pass_arr),
      .arr_data(arr_data), .rd_byte(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stat_q <= '0;
      else if (rd_strobe) stat_q <= rd_byte;
   end
endmodule

// File: rtl/opstat_chk.sv
module opstat_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              ret_read,
   input logic              rd_strobe,
   input logic              op_start,
   input logic              hang,
   input logic              hold6,
   input logic              t6,
   input logic [DATA_W-1:0] stat_q
);
   a_r10_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ret_read |=> !ret_read);
   a_r10_ret_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ret_read |-> !busy);
   a_r5_hang_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hang |=> (hang && busy));
   a_r5_tmo_bit: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[5] |-> hang);
   a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_strobe && !hold6) |=> (t6 != $past(t6)));
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !op_start) |=> $stable(t6));
   a_r11_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hold6 |=> $stable(t6));
endmodule

bind opstat_gen opstat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .ret_read(ret_read),
   .rd_strobe(rd_strobe), .op_start(op_start),
   .hang(state_q == opstat_pkg::ST_HANG), .hold6(hold6),
   .t6(tgl_q[0]), .stat_q(stat_q)
);

// File: tb/opstat_gen_bench.sv
module opstat_gen_bench;
   localparam int PW = 16;
   localparam int EW = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic [2:0] tgt_sector = 3'd0;
   logic       prog_poll_bit = 1'b0;
   logic       tgt_prot = 1'b0;
   logic       op_done = 1'b0;
   logic       tmo = 1'b0;
   logic       susp = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [2:0] rd_sector = 3'd0;
   logic [7:0] arr_data = 8'h00;
   logic [7:0] stat_q;
   logic       busy;
   logic       ret_read;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   opstat_gen #(.SEC_W(3), .DATA_W(8), .PROG_WIN(PW), .ERASE_WIN(EW)) u_opstat_gen (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .tgt_sector(tgt_sector), .prog_poll_bit(prog_poll_bit),
      .tgt_prot(tgt_prot), .op_done(op_done), .tmo(tmo), .susp(susp),
      .rd_strobe(rd_strobe), .rd_sector(rd_sector), .arr_data(arr_data),
      .stat_q(stat_q), .busy(busy), .ret_read(ret_read)
   );

   task automatic ck(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (exp_q.size() != 0) ck("scoreboard drain", 8'(exp_q.size()), 8'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // driver: queue the expected byte, then pulse a read
   task automatic rd(input logic [2:0] s, input logic [7:0] e, input string tag);
      @(negedge clk);
      rd_sector = s;
      rd_strobe = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic start(input logic [1:0] k, input logic [2:0] s, input logic pb, input logic pr);
      @(negedge clk);
      op_start = 1'b1; op_kind = k; tgt_sector = s; prog_poll_bit = pb; tgt_prot = pr;
      @(negedge clk);
      op_start = 1'b0; tgt_prot = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); op_done = 1'b1;
      @(negedge clk); op_done = 1'b0;
   endtask

   task automatic pulse_tmo();
      @(negedge clk); tmo = 1'b1;
      @(negedge clk); tmo = 1'b0;
   endtask

   // monitor: pops the expected byte for each read it sees
   initial begin
      forever begin
         @(posedge clk);
         if (rd_strobe) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               ck("unexpected read", stat_q, 8'hxx);
            end else begin
               ck(tag_q.pop_front(), stat_q, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      ck("R1 busy", {7'd0, busy}, 8'd0);
      ck("R1 ret", {7'd0, ret_read}, 8'd0);
      ck("R1 stat", stat_q, 8'h00);
      rst_n = 1'b1;
      rd(3'd0, 8'h00, "R1 idle read");

      // program, polled bit 1
      start(2'd0, 3'd1, 1'b1, 1'b0);
      ck("R2 busy", {7'd0, busy}, 8'd1);
      rd(3'd0, 8'h40, "R2 R4 R6 R7 prog read1");
      rd(3'd3, 8'h00, "R4 prog read2");
      rd(3'd7, 8'h40, "R4 prog read3");
      pulse_done();
      ck("R10 busy low", {7'd0, busy}, 8'd0);
      ck("R10 ret high", {7'd0, ret_read}, 8'd1);
      @(negedge clk);
      ck("R10 ret one cycle", {7'd0, ret_read}, 8'd0);
      rd(3'd2, 8'hC0, "R2 R4 done read");
      rd(3'd5, 8'hC0, "R4 idle hold");

      // program, polled bit 0, with ignored start
      start(2'd0, 3'd0, 1'b0, 1'b0);
      rd(3'd0, 8'hC0, "R2 prog inverse");
      start(2'd2, 3'd4, 1'b1, 1'b1);
      rd(3'd4, 8'h80, "R12 start ignored");
      pulse_done();
      ck("R12 single ret", {7'd0, ret_read}, 8'd1);
      rd(3'd0, 8'h00, "R2 true bit after done");

      // sector erase on sector 2
      start(2'd1, 3'd2, 1'b0, 1'b0);
      rd(3'd2, 8'h4C, "R3 R6 R7 in sector");
      rd(3'd5, 8'h0C, "R7 out of sector");
      rd(3'd2, 8'h48, "R7 in sector again");
      @(negedge clk); susp = 1'b1; arr_data = 8'h5A;
      rd(3'd5, 8'h5A, "R11 array pass");
      rd(3'd2, 8'h4C, "R11 in sector suspended");
      rd(3'd4, 8'h5A, "R11 array pass 2");
      pulse_done();
      ck("R11 done ignored", {7'd0, busy}, 8'd1);
      @(negedge clk); susp = 1'b0;
      rd(3'd3, 8'h0C, "R11 resume");
      pulse_done();
      ck("R10 erase done", {7'd0, busy}, 8'd0);
      rd(3'd1, 8'h84, "R3 idle after erase");

      // chip erase with timeout
      start(2'd2, 3'd0, 1'b0, 1'b0);
      rd(3'd1, 8'h4C, "R7 chip any sector");
      rd(3'd6, 8'h08, "R7 chip any sector 2");
      pulse_tmo();
      rd(3'd0, 8'h6C, "R5 timeout bit");
      pulse_done();
      ck("R5 done ignored", {7'd0, busy}, 8'd1);
      rd(3'd0, 8'h28, "R5 still hung");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      ck("R1 reset busy", {7'd0, busy}, 8'd0);
      ck("R1 reset stat", stat_q, 8'h00);
      rst_n = 1'b1;
      rd(3'd0, 8'h00, "R1 read after reset");

      // protected program
      start(2'd0, 3'd1, 1'b1, 1'b1);
      n = 1;
      rd(3'd6, 8'h40, "R8 fake busy read");
      n = 3;
      forever begin
         @(negedge clk);
         if (busy) n++;
         else break;
      end
      ck("R8 window", 8'(n), 8'(PW));
      ck("R8 ret", {7'd0, ret_read}, 8'd1);
      rd(3'd0, 8'hC0, "R8 idle read");

      // protected sector erase
      start(2'd1, 3'd4, 1'b0, 1'b1);
      n = 1;
      rd(3'd1, 8'h48, "R9 fake busy read");
      n = 3;
      forever begin
         @(negedge clk);
         if (busy) n++;
         else break;
      end
      ck("R9 window", 8'(n), 8'(EW));
      ck("R9 ret", {7'd0, ret_read}, 8'd1);
      rd(3'd0, 8'hC0, "R9 idle read");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule